// File: doc/BRIEF.md
# Converter start-up sequencer with overflow flag

This block governs the digital output of a four-channel audio converter around power-down. While the active-low power-down input is held low, the data path is muted, the overflow flag is cleared, and the high-pass-enable, master/slave and serial-format selects are captured. The selects keep those captured values for as long as the block runs.

After release, the block counts frame ticks. A frame tick is one edge of the frame clock, sampled in the system clock domain. The mute output stays high for a fixed number of frames, and that number depends on whether the interface is master or slave.

Overflow detection is blanked for the start-up frames. After that, on every frame tick the block compares the magnitude of each channel sample against a fixed near-full-scale level. The result passes through a frame-tick delay line before it reaches the flag, so that the flag lines up with the data it describes.

Top module: `adc_startup_ovf`

## Requirements
- R1: While `pdn_n` is low at a clock edge, `mute` is 1 and, from the next cycle on, `ovf` is 0.
- R2: `hpf_en` takes the value of `hpf_pin` at each clock edge where `pdn_n` is low. It keeps that value while `pdn_n` is high, whatever `hpf_pin` does.
- R3: A frame tick is a rising edge of `frame_clk` when `i2s_sel` was 0 at the last power-down edge, and a falling edge when it was 1. `master_sel` is captured in the same way. Each edge is sampled once by `clk`.
- R4: In master mode (`master_sel`=1), `mute` goes low at the clock edge of the 516th frame tick after release.
- R5: In slave mode (`master_sel`=0), `mute` goes low at the clock edge of the 517th frame tick after release.
- R6: Samples seen on frame ticks 1 to 516 after release never raise `ovf`.
- R7: A channel overflows when the magnitude of its signed two's-complement 24-bit sample is greater than 8103788. Channel k occupies `samples[24k+23:24k]`. A magnitude of exactly 8103788 does not overflow, and -8388608 does. `ovf` reports the OR over all four channels.
- R8: The overflow result of frame tick n appears on `ovf` at the clock edge of tick n+13 and holds until the next tick. The flag is not sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Power-down, active low, synchronous to `clk` |
| frame_clk | input | 1 | Frame clock, sampled by `clk` |
| master_sel | input | 1 | 1 = master interface, 0 = slave |
| i2s_sel | input | 1 | 1 = I2S format (falling-edge frames) |
| hpf_pin | input | 1 | High-pass enable request |
| samples | input | 96 | Four signed 24-bit channel samples, channel 0 in the low bits |
| mute | output | 1 | Force converter output data to zero |
| ovf | output | 1 | Overflow flag, delayed to match the data |
| hpf_en | output | 1 | Captured high-pass enable |

## Verification
The hardest situation to reach is the first overflow just after blanking ends, because it only shows up more than five hundred frames after release and then 13 ticks later still. The stimulus holds full-scale negative samples on one channel through the whole start-up period, so blanking is tested together with the switch-over. It then walks the level across the exact threshold on different channels. The slave/I2S combination needs its own power cycle, since its mute length and its tick edge differ from the master/left-justified run. A behavioural model tracks every one of these frames and is compared against the outputs on every clock.

// File: rtl/adc_startup_ovf.sv
module adc_startup_ovf #(
  parameter int W           = 24,
  parameter int CH          = 4,
  parameter int MUTE_MASTER = 516,
  parameter int ARM_FRAMES  = 516,
  parameter int LATENCY     = 13,
  parameter int LEVEL       = 8103788
) (
  input  logic          clk,
  input  logic          pdn_n,
  input  logic          frame_clk,
  input  logic          master_sel,
  input  logic          i2s_sel,
  input  logic          hpf_pin,
  input  logic [CH*W-1:0] samples,
  output logic          mute,
  output logic          ovf,
  output logic          hpf_en
);
  localparam int MUTE_SLAVE = MUTE_MASTER + 1;
  localparam int CW = $clog2(MUTE_SLAVE + 1);
  localparam logic [W-1:0] LEVEL_V = W'(LEVEL);

  logic          fclk_q, master_q, i2s_q, hpf_q, ovf_q;
  logic [CW-1:0] frames;
  logic [LATENCY-1:0] pipe;
  logic [CH-1:0] over;
  logic          tick, armed;
  logic [CW-1:0] limit;

  for (genvar g = 0; g < CH; g++) begin : g_lane
    logic [W-1:0] s, mag;
    assign s       = samples[g*W +: W];
    assign mag     = s[W-1] ? (~s + W'(1)) : s;
    assign over[g] = mag > LEVEL_V;
  end

  assign tick  = pdn_n & (i2s_q ? (fclk_q & ~frame_clk) : (~fclk_q & frame_clk));
  assign armed = frames >= CW'(ARM_FRAMES);
  assign limit = master_q ? CW'(MUTE_MASTER) : CW'(MUTE_SLAVE);

  always_ff @(posedge clk) begin
    fclk_q <= frame_clk;
    if (!pdn_n) begin
      master_q <= master_sel;
      i2s_q    <= i2s_sel;
      hpf_q    <= hpf_pin;
      frames   <= '0;
      pipe     <= '0;
      ovf_q    <= 1'b0;
    end else if (tick) begin
      if (frames != CW'(MUTE_SLAVE)) frames <= frames + CW'(1);
      pipe  <= {pipe[LATENCY-2:0], armed & (|over)};
      ovf_q <= pipe[LATENCY-1];
    end
  end

  assign mute   = ~pdn_n | (frames < limit);
  assign ovf    = ovf_q;
  assign hpf_en = hpf_q;
endmodule

// File: rtl/adc_startup_ovf_chk.sv
module adc_startup_ovf_chk (
  input logic clk,
  input logic pdn_n,
  input logic frame_clk,
  input logic mute,
  input logic ovf,
  input logic hpf_en
);
  logic pdn_low_q = 1'b0;
  always_ff @(posedge clk) pdn_low_q <= !pdn_n;

  always @(posedge clk)
    if (pdn_low_q) p_pdn_quiet_r1: assert (!ovf && mute);

  p_hpf_hold_r2: assert property (@(posedge clk) disable iff (!pdn_n)
    $past(pdn_n) |-> $stable(hpf_en));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!pdn_n)
    mute |-> !ovf);

  p_mute_done_r4: assert property (@(posedge clk) disable iff (!pdn_n)
    !mute |=> !mute);

  p_flag_on_frame_r8: assert property (@(posedge clk) disable iff (!pdn_n)
    !$stable(ovf) |-> ($past(frame_clk) != $past(frame_clk, 2)));
endmodule

bind adc_startup_ovf adc_startup_ovf_chk u_chk (
  .clk(clk), .pdn_n(pdn_n), .frame_clk(frame_clk),
  .mute(mute), .ovf(ovf), .hpf_en(hpf_en)
);

// File: tb/adc_startup_ovf_test.sv
module adc_startup_ovf_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int LVL   = 8103788;

  logic clk = 1'b0, pdn_n = 1'b0, frame_clk = 1'b0;
  logic master_sel = 1'b1, i2s_sel = 1'b0, hpf_pin = 1'b0;
  logic [95:0] samples = '0;
  logic mute, ovf, hpf_en;

  int vectors = 0, fails = 0, cycles = 0, fdiv = 0;

  adc_startup_ovf uut (.clk(clk), .pdn_n(pdn_n), .frame_clk(frame_clk),
    .master_sel(master_sel), .i2s_sel(i2s_sel), .hpf_pin(hpf_pin),
    .samples(samples), .mute(mute), .ovf(ovf), .hpf_en(hpf_en));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    fdiv = fdiv + 1;
    if (fdiv == HALF) begin fdiv = 0; frame_clk = ~frame_clk; end
  end

  // behavioural reference
  int m_cnt = 0;
  bit m_master, m_i2s, m_hpf, m_prev, m_ovf;
  bit q[$];

  function automatic bit any_over(logic [95:0] s);
    for (int k = 0; k < 4; k++) begin
      longint v = longint'($signed(s[k*24 +: 24]));
      if (v < 0) v = -v;
      if (v > LVL) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!pdn_n) begin
      m_cnt = 0; m_ovf = 0; m_hpf = hpf_pin; m_master = master_sel; m_i2s = i2s_sel;
      q.delete();
      for (int i = 0; i < 13; i++) q.push_back(1'b0);
    end else if (m_i2s ? (m_prev && !frame_clk) : (!m_prev && frame_clk)) begin
      q.push_back((m_cnt >= 516) && any_over(samples));
      m_ovf = q.pop_front();
      if (m_cnt < 517) m_cnt++;
    end
    m_prev = frame_clk;
  end

  task automatic check(input bit act, input bit exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    check(mute, !pdn_n || m_cnt < (m_master ? 516 : 517),
          !pdn_n ? "R1" : (m_i2s ? "R3" : (m_master ? "R4" : "R5")));
    check(ovf, m_ovf, !pdn_n ? "R1" : (m_cnt < 517 ? "R6" : "R8"));
    check(hpf_en, m_hpf, "R2");
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  task automatic frames(input int n);
    repeat (n * 2 * HALF) @(negedge clk);
  endtask

  task automatic put(input int k, input int v);
    samples = '0;
    samples[k*24 +: 24] = 24'(v);
  endtask

  initial begin
    // scenario 1: master, rising-edge frames
    hpf_pin = 1'b1;
    repeat (20) @(negedge clk);
    check(mute, 1'b1, "R1 reset mute");
    check(ovf, 1'b0, "R1 reset flag");
    check(hpf_en, 1'b1, "R2 captured");
    put(2, -8388608);
    pdn_n = 1'b1;
    @(negedge clk);
    hpf_pin = 1'b0;
    frames(510);
    check(mute, 1'b1, "R4 still muted");
    check(ovf, 1'b0, "R6 blanked");
    while (mute) @(negedge clk);
    check(frame_clk, 1'b1, "R3 rising edge tick");
    frames(8);
    check(ovf, 1'b0, "R6 blank plus latency");
    frames(14);
    check(ovf, 1'b1, "R7 negative full scale");
    put(1, LVL);
    frames(20);
    check(ovf, 1'b0, "R7 equal not over");
    put(3, LVL + 1);
    frames(20);
    check(ovf, 1'b1, "R7 just over");
    put(0, -(LVL + 1));
    frames(20);
    check(ovf, 1'b1, "R7 negative over");
    samples = '0;
    frames(12);
    check(ovf, 1'b1, "R8 still delayed");
    frames(20);
    check(ovf, 1'b0, "R8 not sticky");
    check(hpf_en, 1'b1, "R2 pin ignored");

    // scenario 2: slave, I2S falling-edge frames
    pdn_n = 1'b0; master_sel = 1'b0; i2s_sel = 1'b1; hpf_pin = 1'b0;
    repeat (6) @(negedge clk);
    check(hpf_en, 1'b0, "R2 recaptured");
    pdn_n = 1'b1;
    @(negedge clk);
    master_sel = 1'b1; i2s_sel = 1'b0; hpf_pin = 1'b1;
    frames(512);
    check(mute, 1'b1, "R5 still muted");
    while (mute) @(negedge clk);
    check(frame_clk, 1'b0, "R3 falling edge tick");
    put(1, 8388607);
    frames(20);
    check(ovf, 1'b1, "R7 positive full scale");
    pdn_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ovf, 1'b0, "R1 flag cleared");
    check(mute, 1'b1, "R1 muted");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule